// File: doc/BRIEF.md
# Physical address alias remapper

This block sits between bus masters and a 33-bit physical address space. It decodes each request address into one of four regions and produces the final target address. The regions are on-chip SRAM and registers, DRAM, the low alias window, and unmapped space. A high-memory mode moves the whole DRAM window above 4 GB. In that mode the old low DRAM range becomes an alias of the upper window.

Each request carries a tag that marks its master as 32-bit-only or 33-bit capable. In high-memory mode, a 32-bit-only master is lifted into the upper 4 GB by forcing address bit 32 to 1. A 33-bit capable master keeps its address unchanged, so it can still reach DRAM through the low alias range and SRAM through the first gigabyte.

The decoded result is held in one output register with a valid/ready handshake. The mode bit is sampled only while that register is empty. Software must change the mode only while no request is pending.

Top module: `pa_remap`

## Requirements
- R1: After reset, rsp_valid_o is 0 and the block is in normal mode (mode 0).
- R2: In normal mode, an address below 0x4000_0000 decodes to region code 0 (SRAM/registers). The target address equals the request address and rsp_err_o is 0.
- R3: In normal mode, an address from 0x4000_0000 to 0xFFFF_FFFF decodes to region code 1 (DRAM). The target address is unchanged and rsp_err_o is 0.
- R4: In normal mode, any address with bit 32 set decodes to region code 3 (unmapped). The target address is unchanged and rsp_err_o is 1. rsp_err_o is 1 for region 3 only.
- R5: In high-memory mode, a request with req_wide_i=0 (32-bit-only) has bit 32 forced to 1. It yields region code 1 and target address {1, req_addr_i[31:0]}, whatever its low address.
- R6: In high-memory mode, a request with req_wide_i=1 and bit 32 set yields region code 1. The target address is unchanged.
- R7: In high-memory mode, a request with req_wide_i=1 and an address from 0x4000_0000 to 0xFFFF_FFFF yields region code 2 (alias). The target address is the canonical upper address, i.e. the request address with bit 32 set.
- R8: In high-memory mode, a request with req_wide_i=1 and an address below 0x4000_0000 yields region code 0. The target address is unchanged.
- R9: A request is accepted on a clock edge where req_valid_i and req_ready_o are both 1. Its result is visible on the outputs after that edge, with rsp_valid_o=1. req_ready_o = !rsp_valid_o || rsp_ready_i.
- R10: While rsp_valid_o is 1 and rsp_ready_i is 0, rsp_addr_o, rsp_region_o and rsp_err_o hold their values and req_ready_o is 0.
- R11: mode_i is sampled only on clock edges where the output stage is empty. A change made while a result is held is deferred. A request accepted in that same cycle is decoded with the previous mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | High-memory mode request (1 = DRAM above 4 GB) |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high with req_valid_i |
| req_addr_i | input | 33 | Request physical address |
| req_wide_i | input | 1 | Master class: 1 = 33-bit capable, 0 = 32-bit-only |
| rsp_valid_o | output | 1 | Result valid |
| rsp_ready_i | input | 1 | Consumer ready for result |
| rsp_addr_o | output | 33 | Target address |
| rsp_region_o | output | 2 | 0 SRAM/regs, 1 DRAM, 2 alias, 3 unmapped |
| rsp_err_o | output | 1 | Unmapped address error |

## Verification
A wrong mode register shows up on the very next decoded request. Low addresses from 32-bit-only masters come back without bit 32, or alias hits come back as plain DRAM. So the bench walks the same address classes under both modes, one cycle after each accept. A stuck or lost output register shows within one cycle as a missing rsp_valid_o or a changed payload during back-pressure. A mode register that samples too early shows as the request held across a mode change being decoded in the new mode.

// File: rtl/pa_remap_pkg.sv
package pa_remap_pkg;
  typedef enum logic [1:0] {
    RGN_SRAM  = 2'd0,
    RGN_DRAM  = 2'd1,
    RGN_ALIAS = 2'd2,
    RGN_NONE  = 2'd3
  } region_e;
endpackage

// File: rtl/pa_remap_xlate.sv
module pa_remap_xlate
  import pa_remap_pkg::*;
#(
  parameter int ADDR_W = 33,
  parameter int WIN_W  = 30
) (
  input  logic              hi_mode_i,
  input  logic              wide_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output region_e           region_o,
  output logic              err_o
);
  localparam int TOP = ADDR_W - 1;

  logic [ADDR_W-1:0] eff;
  logic              first_win;

  always_comb begin
    eff = addr_i;
    // 32-bit-only masters are lifted into the upper window
    if (hi_mode_i && !wide_i) eff[TOP] = 1'b1;
    first_win = (eff[TOP-1:WIN_W] == '0);
    addr_o    = eff;
    err_o     = 1'b0;
    if (!hi_mode_i) begin
      if (eff[TOP]) begin
        region_o = RGN_NONE;
        err_o    = 1'b1;
      end else if (first_win) begin
        region_o = RGN_SRAM;
      end else begin
        region_o = RGN_DRAM;
      end
    end else begin
      if (eff[TOP]) begin
        region_o = RGN_DRAM;
      end else if (first_win) begin
        region_o = RGN_SRAM;
      end else begin
        region_o   = RGN_ALIAS;
        addr_o[TOP] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pa_remap_stage.sv
module pa_remap_stage #(
  parameter int W = 36
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [W-1:0] in_data_i,
  output logic         out_valid_o,
  input  logic         out_ready_i,
  output logic [W-1:0] out_data_o
);
  logic         vld_q;
  logic [W-1:0] dat_q;

  assign in_ready_o  = !vld_q || out_ready_i;
  assign out_valid_o = vld_q;
  assign out_data_o  = dat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (in_ready_o) begin
      vld_q <= in_valid_i;
      if (in_valid_i) dat_q <= in_data_i;
    end
  end
endmodule

// File: rtl/pa_remap_mode.sv
module pa_remap_mode (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_i,
  input  logic busy_i,
  output logic mode_o
);
  logic mode_q;
  assign mode_o = mode_q;

  // Mode follows the request only while the output stage is empty
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      mode_q <= 1'b0;
    else if (!busy_i) mode_q <= mode_i;
  end
endmodule

// File: rtl/pa_remap.sv
module pa_remap
  import pa_remap_pkg::*;
#(
  parameter int ADDR_W = 33,
  parameter int WIN_W  = 30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_wide_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [ADDR_W-1:0] rsp_addr_o,
  output logic [1:0]        rsp_region_o,
  output logic              rsp_err_o
);
  localparam int PW = ADDR_W + 3;

  logic              hi_mode;
  logic [ADDR_W-1:0] x_addr;
  region_e           x_region;
  logic              x_err;
  logic [PW-1:0]     st_in, st_out;

  pa_remap_mode u_mode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .mode_i (mode_i),
    .busy_i (rsp_valid_o),
    .mode_o (hi_mode)
  );

  pa_remap_xlate #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) u_xlate (
    .hi_mode_i (hi_mode),
    .wide_i    (req_wide_i),
    .addr_i    (req_addr_i),
    .addr_o    (x_addr),
    .region_o  (x_region),
    .err_o     (x_err)
  );

  assign st_in = {x_err, x_region, x_addr};

  pa_remap_stage #(.W(PW)) u_stage (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (req_valid_i),
    .in_ready_o  (req_ready_o),
    .in_data_i   (st_in),
    .out_valid_o (rsp_valid_o),
    .out_ready_i (rsp_ready_i),
    .out_data_o  (st_out)
  );

  assign rsp_addr_o   = st_out[ADDR_W-1:0];
  assign rsp_region_o = st_out[ADDR_W+1:ADDR_W];
  assign rsp_err_o    = st_out[PW-1];
endmodule

// File: rtl/pa_remap_chk.sv
module pa_remap_chk #(
  parameter int ADDR_W = 33,
  parameter int WIN_W  = 30
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic              rsp_ready_i,
  input logic [ADDR_W-1:0] rsp_addr_o,
  input logic [1:0]        rsp_region_o,
  input logic              rsp_err_o
);
  localparam int TOP = ADDR_W - 1;

  // R1
  always_ff @(posedge clk_i)
    if (!rst_ni) a_r1_reset_idle: assert (!rsp_valid_o);

  // R4: error flag only for unmapped
  a_r4_err_is_unmapped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_err_o == (rsp_region_o == 2'd3)));

  // R4: unmapped results always carry bit 32
  a_r4_unmapped_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_region_o == 2'd3) |-> rsp_addr_o[TOP]);

  // R7: alias results are resolved to the upper window
  a_r7_alias_resolved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_region_o == 2'd2) |-> rsp_addr_o[TOP]);

  // R2, R8: SRAM results lie in the first window
  a_r8_sram_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_region_o == 2'd0) |-> (rsp_addr_o[TOP:WIN_W] == '0));

  // R9
  a_r9_accept_shows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> rsp_valid_o);

  a_r9_ready_when_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_o |-> req_ready_o);

  // R10
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=>
      (rsp_valid_o && $stable(rsp_addr_o) && $stable(rsp_region_o) && $stable(rsp_err_o)));
endmodule

bind pa_remap pa_remap_chk #(.ADDR_W(ADDR_W), .WIN_W(WIN_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_ready_i  (rsp_ready_i),
  .rsp_addr_o   (rsp_addr_o),
  .rsp_region_o (rsp_region_o),
  .rsp_err_o    (rsp_err_o)
);

// File: tb/pa_remap_test.sv
`timescale 1ns/1ps
module pa_remap_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [32:0] req_addr_i = '0;
  logic        req_wide_i = 1'b0;
  logic        rsp_valid_o;
  logic        rsp_ready_i = 1'b1;
  logic [32:0] rsp_addr_o;
  logic [1:0]  rsp_region_o;
  logic        rsp_err_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk_i = ~clk_i;

  pa_remap uut (.*);

  // {mode, wide, addr, region, target}
  localparam int NV = 14;
  localparam logic [69:0] VEC [NV] = '{
    {1'b0, 1'b0, 33'h0_1000_0000, 2'd0, 33'h0_1000_0000}, // R2
    {1'b0, 1'b1, 33'h0_3FFF_FFFF, 2'd0, 33'h0_3FFF_FFFF}, // R2
    {1'b0, 1'b0, 33'h0_4000_0000, 2'd1, 33'h0_4000_0000}, // R3
    {1'b0, 1'b1, 33'h0_FFFF_FFFF, 2'd1, 33'h0_FFFF_FFFF}, // R3
    {1'b0, 1'b1, 33'h1_2345_6780, 2'd3, 33'h1_2345_6780}, // R4
    {1'b0, 1'b0, 33'h1_0000_0000, 2'd3, 33'h1_0000_0000}, // R4
    {1'b1, 1'b0, 33'h0_4000_0000, 2'd1, 33'h1_4000_0000}, // R5
    {1'b1, 1'b0, 33'h0_0000_1000, 2'd1, 33'h1_0000_1000}, // R5
    {1'b1, 1'b1, 33'h1_8000_0000, 2'd1, 33'h1_8000_0000}, // R6
    {1'b1, 1'b1, 33'h0_4000_0000, 2'd2, 33'h1_4000_0000}, // R7
    {1'b1, 1'b1, 33'h0_FFFF_FFFC, 2'd2, 33'h1_FFFF_FFFC}, // R7
    {1'b1, 1'b1, 33'h0_3FFF_FFFF, 2'd0, 33'h0_3FFF_FFFF}, // R8
    {1'b1, 1'b0, 33'h1_0000_0010, 2'd1, 33'h1_0000_0010}, // R5
    {1'b0, 1'b0, 33'h0_8000_0000, 2'd1, 33'h0_8000_0000}  // R3
  };

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic set_mode(input logic m);
    @(negedge clk_i);
    mode_i = m;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 valid in reset", rsp_valid_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 valid after reset", rsp_valid_o, 0);
    check("R9 ready when empty", req_ready_o, 1);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [69:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R2-R8 vec %0d", i);
      set_mode(v[69]);
      req_wide_i  = v[68];
      req_addr_i  = v[67:35];
      req_valid_i = 1'b1;
      #1 check("R9 no early valid", rsp_valid_o, 0);
      @(negedge clk_i);
      req_valid_i = 1'b0;
      check({tag, " valid R9"}, rsp_valid_o, 1);
      check({tag, " region"}, rsp_region_o, v[34:33]);
      check({tag, " addr"}, rsp_addr_o, v[32:0]);
      check({tag, " err R4"}, rsp_err_o, (v[34:33] == 2'd3));
    end

    // R10 hold under back-pressure, R11 deferred mode change
    set_mode(1'b0);
    rsp_ready_i = 1'b0;
    req_wide_i  = 1'b0;
    req_addr_i  = 33'h0_0000_2000;
    req_valid_i = 1'b1;
    @(negedge clk_i);
    req_addr_i = 33'h0_0000_3000;   // second request waits
    mode_i     = 1'b1;              // change while a result is held
    check("R10 ready low when held", req_ready_o, 0);
    repeat (3) @(negedge clk_i);
    check("R10 held valid", rsp_valid_o, 1);
    check("R10 held addr", rsp_addr_o, 33'h0_0000_2000);
    check("R10 held region", rsp_region_o, 0);
    rsp_ready_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    // second request decoded with old (normal) mode
    check("R11 deferred addr", rsp_addr_o, 33'h0_0000_3000);
    check("R11 deferred region", rsp_region_o, 0);
    repeat (2) @(negedge clk_i);
    req_addr_i  = 33'h0_0000_3000;
    req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    check("R11 mode applied addr", rsp_addr_o, 33'h1_0000_3000);
    check("R11 mode applied region", rsp_region_o, 1);

    // R9 back-to-back throughput
    set_mode(1'b1);
    req_wide_i  = 1'b1;
    req_addr_i  = 33'h0_5000_0000;
    req_valid_i = 1'b1;
    @(negedge clk_i);
    check("R9 b2b ready", req_ready_o, 1);
    req_addr_i = 33'h0_0000_0040;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    check("R9 b2b second region", rsp_region_o, 0);
    check("R9 b2b second addr", rsp_addr_o, 33'h0_0000_0040);
    @(negedge clk_i);
    check("R9 drains", rsp_valid_o, 0);

    // R1 mode returns to normal on reset
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1 reset clears valid", rsp_valid_o, 0);
    mode_i = 1'b0;
    rst_ni = 1'b1;
    req_wide_i  = 1'b0;
    req_addr_i  = 33'h1_0000_0000;
    req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    check("R1 normal mode after reset", rsp_region_o, 3);

    done = 1'b1;
    finish_run();
  end
endmodule